// File: doc/BRIEF.md
# Pulse-Width Coded Bit Decoder

This block turns a single asynchronous input line into a stream of bits. Every bit occupies one period that opens with a rising edge of the line. A short high phase, roughly a fifth of the period, carries a 0. A long high phase, roughly four fifths of the period, carries a 1. The line passes through a two-flop synchroniser, and rising edges are found on the synchronised level. After each edge a counter waits a fixed number of system clock cycles and then reads the line level; that level is the decoded bit.

Decoded bits leave through a valid/ready port that holds one entry. `bit_valid_o` stays high, with `bit_data_o` frozen, until the consumer raises `bit_ready_i`. The decoder cannot be paused, so a bit that completes while the entry is still occupied and not being taken is dropped, and the older bit stays in the entry. A plain enable input gates the decoder. After the enable rises, the decoder waits a settling interval before it accepts any edge. While armed, a separate timeout pulse reports a line that holds either level for too long.

All timing is set by parameters counted in system clock cycles. The defaults assume a 50 MHz clock and a 70 kHz bit rate, sampling at half a period, with a 16 ms phase limit and three periods of settling.

Top module: `pwc_bit_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bit_valid_o` and `timeout_o` are 0.
- R2: A bit whose synchronised high phase lasts `SAMPLE_DLY` clock cycles or fewer decodes as 0.
- R3: A bit whose synchronised high phase lasts at least `SAMPLE_DLY`+1 clock cycles decodes as 1.
- R4: Each rising edge accepted while armed delivers exactly one bit, in arrival order.
- R5: A low phase between bits may be stretched well beyond the nominal period, as long as it stays below `TIMEOUT_CYC` cycles, without changing any decoded value.
- R6: Rising edges are ignored while `enable_i` is 0 and during the first `GUARD_CYC` cycles after `enable_i` goes to 1.
- R7: Once `bit_valid_o` is 1 it stays 1, with `bit_data_o` unchanged, until a cycle in which `bit_ready_i` is 1.
- R8: A bit that completes while the output entry is full and `bit_ready_i` is 0 is discarded, and the entry keeps the older bit.
- R9: While armed, a line level that stays unchanged for `TIMEOUT_CYC` cycles raises `timeout_o` for exactly one cycle. The pulse fires once per unchanged phase, and the decoder goes on decoding normally afterwards. With the enable low, `timeout_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Raw coded data line, asynchronous to `clk_i` |
| enable_i | input | 1 | Decoder enable; rising starts the settling interval |
| bit_data_o | output | 1 | Decoded bit value |
| bit_valid_o | output | 1 | Output entry holds a bit |
| bit_ready_i | input | 1 | Consumer takes the bit in this cycle |
| timeout_o | output | 1 | One-cycle pulse on an over-long line phase |

## Verification
The bench builds the decoder with a 20-cycle nominal bit period, sampling 10 cycles after each edge, a 60-cycle phase limit and a 60-cycle settling interval. These short settings let a few hundred cycles cover the whole behaviour: the exact sampling boundary (high phases of 10 and 11 cycles), stretched gaps just below the limit, the settling window after enable, an idle line and a stuck-high line each producing a single timeout, and the drop of a bit that arrives while the output entry is held.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  // edge-tracking state of the sampler
  typedef enum logic {
    TRK_IDLE = 1'b0,
    TRK_WAIT = 1'b1
  } track_e;
endpackage

// File: rtl/pwc_sync.sv
module pwc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic lvl_o,
  output logic rise_o,
  output logic chg_o
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain_q;
  logic         prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[TOP-1:0], async_i};
      prev_q  <= chain_q[TOP];
    end
  end

  assign lvl_o  = chain_q[TOP];
  assign rise_o = chain_q[TOP] & ~prev_q;
  assign chg_o  = chain_q[TOP] ^ prev_q;
endmodule

// File: rtl/pwc_guard.sv
module pwc_guard #(
  parameter int GUARD_CYC = 2142
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  output logic armed_o
);
  localparam int GW = $clog2(GUARD_CYC + 1);
  localparam logic [GW-1:0] GLIM = GW'(GUARD_CYC);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!enable_i) begin
      cnt_q <= '0;
    end else if (cnt_q != GLIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign armed_o = enable_i && (cnt_q == GLIM);
endmodule

// File: rtl/pwc_sampler.sv
module pwc_sampler
  import pwc_pkg::*;
#(
  parameter int SAMPLE_DLY  = 357,
  parameter int TIMEOUT_CYC = 800000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic lvl_i,
  input  logic rise_i,
  input  logic chg_i,
  output logic evt_o,
  output logic bit_o,
  output logic tmo_o
);
  localparam int DW = $clog2(SAMPLE_DLY + 1);
  localparam int PW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [DW-1:0] DLAST = DW'(SAMPLE_DLY - 1);
  localparam logic [PW-1:0] PLAST = PW'(TIMEOUT_CYC - 1);

  track_e        st_q;
  logic [DW-1:0] dcnt_q;
  logic [PW-1:0] pcnt_q;
  logic          fired_q;
  logic          hit;

  // phase-length watchdog on the synchronised level
  assign hit = armed_i && !chg_i && !fired_q && (pcnt_q == PLAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q  <= '0;
      fired_q <= 1'b0;
      tmo_o   <= 1'b0;
    end else begin
      tmo_o <= hit;
      if (!armed_i || chg_i) begin
        pcnt_q  <= '0;
        fired_q <= 1'b0;
      end else begin
        if (pcnt_q != PLAST) pcnt_q <= pcnt_q + 1'b1;
        if (hit) fired_q <= 1'b1;
      end
    end
  end

  // delayed sample after each rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TRK_IDLE;
      dcnt_q <= '0;
      evt_o  <= 1'b0;
      bit_o  <= 1'b0;
    end else begin
      evt_o <= 1'b0;
      if (!armed_i || hit) begin
        st_q   <= TRK_IDLE;
        dcnt_q <= '0;
      end else begin
        unique case (st_q)
          TRK_IDLE: begin
            if (rise_i) begin
              st_q   <= TRK_WAIT;
              dcnt_q <= '0;
            end
          end
          TRK_WAIT: begin
            if (dcnt_q == DLAST) begin
              st_q  <= TRK_IDLE;
              evt_o <= 1'b1;
              bit_o <= lvl_i;
            end else begin
              dcnt_q <= dcnt_q + 1'b1;
            end
          end
          default: st_q <= TRK_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwc_slot.sv
module pwc_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic bit_i,
  input  logic ready_i,
  output logic valid_o,
  output logic data_o
);
  logic take;

  assign take = evt_i && (!valid_o || ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= 1'b0;
    end else if (take) begin
      valid_o <= 1'b1;
      data_o  <= bit_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pwc_bit_decoder.sv
module pwc_bit_decoder #(
  parameter int BIT_CYC     = 714,
  parameter int SAMPLE_DLY  = BIT_CYC / 2,
  parameter int TIMEOUT_CYC = 800000,
  parameter int GUARD_CYC   = 3 * BIT_CYC,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic enable_i,
  output logic bit_data_o,
  output logic bit_valid_o,
  input  logic bit_ready_i,
  output logic timeout_o
);
  logic lvl, rise, chg, armed, evt, smp;

  pwc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(line_i),
    .lvl_o(lvl), .rise_o(rise), .chg_o(chg)
  );

  pwc_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .armed_o(armed)
  );

  pwc_sampler #(.SAMPLE_DLY(SAMPLE_DLY), .TIMEOUT_CYC(TIMEOUT_CYC)) u_smp (
    .clk_i(clk_i), .rst_ni(rst_ni), .armed_i(armed), .lvl_i(lvl),
    .rise_i(rise), .chg_i(chg), .evt_o(evt), .bit_o(smp), .tmo_o(timeout_o)
  );

  pwc_slot u_slot (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt), .bit_i(smp),
    .ready_i(bit_ready_i), .valid_o(bit_valid_o), .data_o(bit_data_o)
  );
endmodule

// File: rtl/pwc_bit_decoder_chk.sv
module pwc_bit_decoder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic bit_ready_i,
  input logic bit_valid_o,
  input logic bit_data_o,
  input logic timeout_o
);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |=> (!bit_valid_o && !timeout_o));

  a_r6_no_bit_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !bit_valid_o) |=> !bit_valid_o);

  a_r7_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && !bit_ready_i) |=> (bit_valid_o && $stable(bit_data_o)));

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  a_r9_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !timeout_o);
endmodule

bind pwc_bit_decoder pwc_bit_decoder_chk u_chk (.*);

// File: tb/pwc_bit_decoder_test.sv
module pwc_bit_decoder_test;
  localparam int SDLY = 10;
  localparam int NV = 10;
  localparam int VH [NV] = '{4, 16, 16, 4, 11, 10, 4, 16, 12, 3};
  localparam int VL [NV] = '{16, 4, 4, 16, 9, 10, 45, 45, 8, 17};
  localparam int VB [NV] = '{0, 1, 1, 0, 1, 0, 0, 1, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic en = 1'b1;
  logic rdy = 1'b1;
  logic bdata, bvalid, tmo;

  int checks = 0;
  int errors = 0;
  int rx_cnt = 0;
  int t_cnt = 0;
  logic rx_data [0:255];

  always #10 clk = ~clk;

  pwc_bit_decoder #(.BIT_CYC(20), .SAMPLE_DLY(SDLY), .TIMEOUT_CYC(60),
                    .GUARD_CYC(60)) uut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .enable_i(en),
    .bit_data_o(bdata), .bit_valid_o(bvalid), .bit_ready_i(rdy),
    .timeout_o(tmo)
  );

  // monitor: samples at the falling edge, inputs move at rise+3
  always @(negedge clk) begin
    if (rst_n) begin
      if (bvalid && rdy) begin
        rx_data[rx_cnt[7:0]] = bdata;
        rx_cnt = rx_cnt + 1;
      end
      if (tmo) t_cnt = t_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #3;
    end
  endtask

  task automatic pulse(input int h, input int l);
    line = 1'b1;
    step(h);
    line = 1'b0;
    step(l);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    int base, tbase;
    step(5);
    @(negedge clk);
    chk(!bvalid && !tmo, "R1 in reset", {bvalid, tmo}, 0);
    @(posedge clk); #3;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bvalid && !tmo, "R1 after reset", {bvalid, tmo}, 0);

    // idle line after arming: one timeout only (R9)
    step(150);
    chk(t_cnt == 1, "R9 idle timeout once", t_cnt, 1);

    // vector table: R2 R3 R4 R5
    base = rx_cnt;
    tbase = t_cnt;
    for (int i = 0; i < NV; i++) pulse(VH[i], VL[i]);
    chk(t_cnt == tbase, "R5 no timeout on stretched gaps", t_cnt - tbase, 0);
    step(10);
    chk(rx_cnt - base == NV, "R4 one bit per edge", rx_cnt - base, NV);
    for (int i = 0; i < NV; i++) begin
      chk(rx_data[8'(base + i)] == VB[i][0],
          (VB[i] != 0) ? "R3 long high reads 1" : "R2 short high reads 0",
          rx_data[8'(base + i)], VB[i]);
    end

    // enable gating (R6)
    en = 1'b0;
    step(3);
    base = rx_cnt;
    pulse(16, 4);
    pulse(16, 4);
    step(10);
    chk(rx_cnt == base, "R6 disabled edges ignored", rx_cnt - base, 0);
    en = 1'b1;
    step(1);
    pulse(16, 20);
    chk(rx_cnt == base, "R6 settling edges ignored", rx_cnt - base, 0);
    step(30);
    pulse(16, 4);
    step(10);
    chk(rx_cnt == base + 1 && rx_data[8'(base)] == 1'b1, "R6 armed edge decoded",
        rx_cnt - base, 1);

    // back-pressure: hold then drop (R7 R8)
    rdy = 1'b0;
    base = rx_cnt;
    pulse(16, 4);
    pulse(4, 16);
    step(5);
    @(negedge clk);
    chk(bvalid && bdata, "R7 held entry", {bvalid, bdata}, 3);
    chk(rx_cnt == base, "R7 nothing taken while not ready", rx_cnt - base, 0);
    @(posedge clk); #3;
    rdy = 1'b1;
    step(5);
    chk(rx_cnt == base + 1, "R8 later bit dropped", rx_cnt - base, 1);
    chk(rx_data[8'(base)] == 1'b1, "R8 older bit kept", rx_data[8'(base)], 1);
    @(negedge clk);
    chk(!bvalid, "R8 entry empty after take", bvalid, 0);

    // stuck high, then recovery (R9)
    step(1);
    base = rx_cnt;
    tbase = t_cnt;
    line = 1'b1;
    step(200);
    chk(t_cnt - tbase == 1, "R9 stuck high single pulse", t_cnt - tbase, 1);
    chk(rx_cnt - base == 1 && rx_data[8'(base)] == 1'b1, "R9 stuck high bit",
        rx_cnt - base, 1);
    line = 1'b0;
    step(20);
    base = rx_cnt;
    pulse(4, 16);
    step(10);
    chk(rx_cnt - base == 1 && rx_data[8'(base)] == 1'b0, "R9 decode after timeout",
        rx_cnt - base, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule